// File: doc/BRIEF.md
# Branch Target Address Generator

This block works out the next program counter for the control transfers of a small 8-bit processor core. The decoder pulses `start` with a target kind and the instruction fields. A relative hop, a full 16-bit jump, a short call into a fixed 2 KB window, or a jump through a register pair is resolved arithmetically. The block then presents the new counter one clock later with a one-cycle `pc_valid` pulse.

Two kinds need memory: a call through a 32-entry table of 16-bit entries in low memory, and a reload of the start address from the vector at the bottom of memory. For these the block reads two bytes over a request/acknowledge byte port, lower (even) address first. It joins them low byte first into the new counter. Leaving reset always starts that vector reload without being asked. While a fetch is in progress, new `start` pulses are dropped. `pc_out` keeps its last value between pulses.

Top module: `branch_target_gen`

## Requirements
- R1: Kind code 0 (relative): one cycle after an accepted `start`, `pc_valid` is 1 and `pc_out` equals `next_pc` plus `disp` sign-extended from bit 7. The sum is taken modulo 65536.
- R2: Kind code 1 (absolute): one cycle after an accepted `start`, `pc_out` equals `{arg_hi, arg_lo}` and `pc_valid` is 1.
- R3: Kind code 2 (short call): one cycle after an accepted `start`, `pc_out` has bits 15..11 = 00001, bits 10..8 = `op_byte[6:4]`, and bits 7..0 = `arg_lo`, with `pc_valid` at 1.
- R4: Kind code 4 (register-indirect): one cycle after an accepted `start`, `pc_out` equals `rp_val` and `pc_valid` is 1.
- R5: Kind code 3 (table call): from the cycle after `start`, `rd_req` is high with `rd_addr` = 0x0040 + 2*`op_byte[5:1]`. After that address is acknowledged, `rd_addr` moves to the next odd address. `rd_req` and `rd_addr` hold steady while `rd_ack` is low.
- R6: For a table or vector fetch, `pc_out` = {byte returned for the odd address, byte returned for the even address}. `pc_valid` pulses in the cycle after the odd address is acknowledged, and `rd_req` falls in that same cycle.
- R7: While `rst` is high, and from its release until acknowledged, `rd_req` is 1 with `rd_addr` = 0x0000. The vector {byte at 0x0001, byte at 0x0000} is then delivered as in R6. Kind code 5 repeats this vector fetch on request.
- R8: A `start` is accepted only while `rd_req` is low. A `start` during a fetch, and any `start` with kind code 6 or 7, causes no `pc_valid` pulse, no read request and no change of `pc_out`.
- R9: While `rst` is high, `pc_valid` is 0 and `pc_out` is 0x0000. In every cycle without a `pc_valid` pulse, `pc_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a target computation |
| kind | input | 3 | Target kind: 0 rel, 1 abs, 2 short, 3 table, 4 reg, 5 vector |
| next_pc | input | 16 | Address of the following instruction |
| op_byte | input | 8 | Opcode byte (short-call high bits, table index) |
| arg_lo | input | 8 | Immediate low byte |
| arg_hi | input | 8 | Immediate high byte |
| disp | input | 8 | Signed relative displacement |
| rp_val | input | 16 | Register pair value |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | 16 | Byte read address |
| rd_ack | input | 1 | Read response valid this cycle |
| rd_data | input | 8 | Read response byte |
| pc_out | output | 16 | New program counter |
| pc_valid | output | 1 | One-cycle strobe marking a fresh `pc_out` |

## Verification
The four arithmetic kinds are due exactly one clock after the `start` edge. A fetch result is due one clock after the edge that takes the odd-address acknowledge. The fetch latency varies because the bench's byte responder waits zero, one or two cycles before acknowledging. The reference model in the bench decides, from the inputs it drives before each rising edge, whether a pulse and which counter value must appear after that edge. It then compares `pc_valid`, `pc_out`, `rd_req` and `rd_addr` at the following falling edge, every cycle. No result is therefore looked for a cycle early or late, and a stray pulse, a dropped hold or a request at the wrong address shows up in the cycle it happens.

// File: rtl/btg_pkg.sv
package btg_pkg;

    localparam int PC_W     = 16;
    localparam int BYTE_W   = 8;
    localparam int SHORT_W  = 11;
    localparam int TIDX_W   = 5;
    localparam int KIND_W   = 3;

    typedef enum logic [KIND_W-1:0] {
        KIND_REL   = 3'd0,
        KIND_ABS   = 3'd1,
        KIND_SHORT = 3'd2,
        KIND_TABLE = 3'd3,
        KIND_REG   = 3'd4,
        KIND_VEC   = 3'd5
    } tgt_kind_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_LO   = 2'd1,
        FS_HI   = 2'd2
    } fetch_st_e;

    function automatic logic is_direct_kind(input logic [KIND_W-1:0] k);
        return (k == KIND_REL) || (k == KIND_ABS) ||
               (k == KIND_SHORT) || (k == KIND_REG);
    endfunction

    function automatic logic is_fetch_kind(input logic [KIND_W-1:0] k);
        return (k == KIND_TABLE) || (k == KIND_VEC);
    endfunction

endpackage

// File: rtl/btg_direct_calc.sv
module btg_direct_calc
    import btg_pkg::*;
#(
    parameter int AW = PC_W,
    parameter int BW = BYTE_W,
    parameter int SW = SHORT_W
) (
    input  logic [KIND_W-1:0] kind,
    input  logic [AW-1:0]     next_pc,
    input  logic [BW-1:0]     op_byte,
    input  logic [BW-1:0]     arg_lo,
    input  logic [BW-1:0]     arg_hi,
    input  logic [BW-1:0]     disp,
    input  logic [AW-1:0]     rp_val,
    output logic [AW-1:0]     target
);
    // Opcode bits that supply the upper part of the short-call field.
    localparam int OPF_W   = SW - BW;
    localparam int WIN_PAD = AW - SW - 1;

    logic [AW-1:0] disp_ext;
    logic [AW-1:0] rel_tgt;
    logic [AW-1:0] short_tgt;

    assign disp_ext  = {{(AW-BW){disp[BW-1]}}, disp};
    // Carry out of the top bit is dropped by the width of the sum.
    assign rel_tgt   = next_pc + disp_ext;
    assign short_tgt = {{WIN_PAD{1'b0}}, 1'b1, op_byte[OPF_W+3:4], arg_lo};

    always_comb begin
        unique case (kind)
            KIND_REL:   target = rel_tgt;
            KIND_ABS:   target = {arg_hi, arg_lo};
            KIND_SHORT: target = short_tgt;
            KIND_REG:   target = rp_val;
            default:    target = '0;
        endcase
    end

endmodule

// File: rtl/btg_fetch.sv
module btg_fetch
    import btg_pkg::*;
#(
    parameter int AW = PC_W,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [AW-1:0] base,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [BW-1:0] rd_data,
    output logic          done,
    output logic [AW-1:0] word
);
    fetch_st_e     state;
    logic [AW-1:0] addr_q;
    logic [BW-1:0] lo_q;

    // Reset lands in the low-byte phase at address zero: the start vector
    // is fetched without any request from the decoder.
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= FS_LO;
            addr_q <= '0;
            lo_q   <= '0;
        end else begin
            unique case (state)
                FS_IDLE: if (go) begin
                    state  <= FS_LO;
                    addr_q <= base;
                end
                FS_LO: if (rd_ack) begin
                    state  <= FS_HI;
                    lo_q   <= rd_data;
                    addr_q <= addr_q | AW'(1);
                end
                FS_HI: if (rd_ack) begin
                    state <= FS_IDLE;
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    assign rd_req  = (state != FS_IDLE);
    assign rd_addr = addr_q;
    assign done    = (state == FS_HI) && rd_ack;
    assign word    = {rd_data, lo_q};

endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen
    import btg_pkg::*;
#(
    parameter int AW  = PC_W,
    parameter int BW  = BYTE_W,
    parameter int SW  = SHORT_W,
    parameter int IW  = TIDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [KIND_W-1:0] kind,
    input  logic [AW-1:0]     next_pc,
    input  logic [BW-1:0]     op_byte,
    input  logic [BW-1:0]     arg_lo,
    input  logic [BW-1:0]     arg_hi,
    input  logic [BW-1:0]     disp,
    input  logic [AW-1:0]     rp_val,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    input  logic              rd_ack,
    input  logic [BW-1:0]     rd_data,
    output logic [AW-1:0]     pc_out,
    output logic              pc_valid
);
    // Table region begins right above the entry-pair span of the index.
    localparam logic [AW-1:0] TBL_BASE = AW'(1) << (IW + 1);

    logic [AW-1:0] direct_tgt;
    logic [AW-1:0] fetch_base;
    logic [AW-1:0] fetch_word;
    logic          fetch_done;
    logic          accept;
    logic          go_fetch;

    assign accept   = start && !rd_req;
    assign go_fetch = accept && is_fetch_kind(kind);

    always_comb begin
        if (kind == KIND_TABLE)
            fetch_base = TBL_BASE | (AW'(op_byte[IW:1]) << 1);
        else
            fetch_base = '0;
    end

    btg_direct_calc #(.AW(AW), .BW(BW), .SW(SW)) u_calc (
        .kind    (kind),
        .next_pc (next_pc),
        .op_byte (op_byte),
        .arg_lo  (arg_lo),
        .arg_hi  (arg_hi),
        .disp    (disp),
        .rp_val  (rp_val),
        .target  (direct_tgt)
    );

    btg_fetch #(.AW(AW), .BW(BW)) u_fetch (
        .clk     (clk),
        .rst     (rst),
        .go      (go_fetch),
        .base    (fetch_base),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .rd_ack  (rd_ack),
        .rd_data (rd_data),
        .done    (fetch_done),
        .word    (fetch_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_out   <= '0;
            pc_valid <= 1'b0;
        end else if (fetch_done) begin
            pc_out   <= fetch_word;
            pc_valid <= 1'b1;
        end else if (accept && is_direct_kind(kind)) begin
            pc_out   <= direct_tgt;
            pc_valid <= 1'b1;
        end else begin
            pc_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/btg_checker.sv
module btg_checker
    import btg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [KIND_W-1:0] kind,
    input logic [15:0]       next_pc,
    input logic [7:0]        op_byte,
    input logic [7:0]        arg_lo,
    input logic [7:0]        disp,
    input logic              rd_req,
    input logic [15:0]       rd_addr,
    input logic              rd_ack,
    input logic [7:0]        rd_data,
    input logic [15:0]       pc_out,
    input logic              pc_valid
);
    assert_rel_target_R1: assert property (@(posedge clk) disable iff (rst)
        (start && !rd_req && kind == KIND_REL) |=>
        (pc_valid && pc_out == $past(next_pc) + {{8{$past(disp[7])}}, $past(disp)}));

    assert_short_window_R3: assert property (@(posedge clk) disable iff (rst)
        (start && !rd_req && kind == KIND_SHORT) |=>
        (pc_valid && pc_out[15:11] == 5'b00001 && pc_out[7:0] == $past(arg_lo)));

    assert_fetch_region_R5: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_addr[15:7] == 9'd0));

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    assert_odd_follows_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_ack && !rd_addr[0]) |=>
        (rd_req && rd_addr == $past(rd_addr) + 16'd1));

    assert_high_byte_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_ack && rd_addr[0]) |=>
        (pc_valid && !rd_req && pc_out[15:8] == $past(rd_data)));

    assert_busy_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !(rd_ack && rd_addr[0])) |=> !pc_valid);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !pc_valid |-> $stable(pc_out));

endmodule

bind branch_target_gen btg_checker u_btg_checker (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .kind     (kind),
    .next_pc  (next_pc),
    .op_byte  (op_byte),
    .arg_lo   (arg_lo),
    .disp     (disp),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_ack   (rd_ack),
    .rd_data  (rd_data),
    .pc_out   (pc_out),
    .pc_valid (pc_valid)
);

// File: tb/branch_target_gen_bench.sv
module branch_target_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  kind = 3'd0;
    logic [15:0] next_pc = 16'h0;
    logic [7:0]  op_byte = 8'h0;
    logic [7:0]  arg_lo = 8'h0;
    logic [7:0]  arg_hi = 8'h0;
    logic [7:0]  disp = 8'h0;
    logic [15:0] rp_val = 16'h0;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_ack = 1'b0;
    logic [7:0]  rd_data = 8'h0;
    logic [15:0] pc_out;
    logic        pc_valid;

    int total = 0;
    int bad = 0;

    // Reference model state.
    bit          m_busy = 1'b1;
    logic [15:0] m_addr = 16'h0;
    logic [7:0]  m_lo = 8'h0;
    logic [15:0] m_held = 16'h0;
    int          lat = 0;
    int          wait_cnt = 0;
    string       tag = "R9";

    always #10 clk = ~clk;

    branch_target_gen u_branch_target_gen (
        .clk(clk), .rst(rst), .start(start), .kind(kind), .next_pc(next_pc),
        .op_byte(op_byte), .arg_lo(arg_lo), .arg_hi(arg_hi), .disp(disp),
        .rp_val(rp_val), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .rd_data(rd_data), .pc_out(pc_out), .pc_valid(pc_valid)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return (a[7:0] * 8'd37) ^ 8'hA5;
    endfunction

    task automatic check(input string t, input logic [15:0] act,
                         input logic [15:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    // One clock: model decides before the edge, outputs compared after it.
    task automatic step();
        bit          dv = 1'b0;
        logic [15:0] dpc = 16'h0;
        bit          ack = 1'b0;
        logic [7:0]  data = 8'h0;
        check(tag, {15'd0, rd_req}, {15'd0, m_busy}, "rd_req");
        if (m_busy) check(tag, rd_addr, m_addr, "rd_addr");
        if (!rst && rd_req) begin
            if (wait_cnt >= lat) begin
                ack = 1'b1;
                data = mem_byte(rd_addr);
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end
        rd_ack = ack;
        rd_data = data;
        if (!rst) begin
            if (m_busy) begin
                if (ack) begin
                    if (!m_addr[0]) begin
                        m_lo = data;
                        m_addr = m_addr + 16'd1;
                    end else begin
                        dv = 1'b1;
                        dpc = {data, m_lo};
                        m_busy = 1'b0;
                    end
                end
            end else if (start) begin
                case (kind)
                    3'd0: begin dv = 1'b1; dpc = next_pc + {{8{disp[7]}}, disp}; end
                    3'd1: begin dv = 1'b1; dpc = {arg_hi, arg_lo}; end
                    3'd2: begin dv = 1'b1; dpc = {5'b00001, op_byte[6:4], arg_lo}; end
                    3'd4: begin dv = 1'b1; dpc = rp_val; end
                    3'd3: begin m_busy = 1'b1; m_addr = 16'h0040 + {10'd0, op_byte[5:1], 1'b0}; end
                    3'd5: begin m_busy = 1'b1; m_addr = 16'h0000; end
                    default: ;
                endcase
            end
        end
        @(negedge clk);
        check(tag, {15'd0, pc_valid}, {15'd0, dv}, "pc_valid");
        if (dv) m_held = dpc;
        check(tag, pc_out, m_held, "pc_out");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic issue(input string t, input logic [2:0] k,
                         input logic [15:0] npc, input logic [7:0] op,
                         input logic [7:0] lo, input logic [7:0] hi,
                         input logic [7:0] d, input logic [15:0] rp);
        tag = t;
        kind = k; next_pc = npc; op_byte = op; arg_lo = lo;
        arg_hi = hi; disp = d; rp_val = rp;
        start = 1'b1;
        step();
        start = 1'b0;
    endtask

    initial begin
        #4000000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R9 / R7: reset state, vector address requested during reset.
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            tag = "R9";
            check(tag, {15'd0, pc_valid}, 16'd0, "pc_valid in reset");
            check(tag, pc_out, 16'h0000, "pc_out in reset");
            tag = "R7";
            check(tag, {15'd0, rd_req}, 16'd1, "rd_req in reset");
            check(tag, rd_addr, 16'h0000, "rd_addr in reset");
            @(negedge clk);
        end
        rst = 1'b0;
        tag = "R7";
        lat = 1;
        idle(8);

        // R1: relative targets, including extremes and wrap.
        lat = 0;
        issue("R1", 3'd0, 16'h1234, 8'h00, 8'h00, 8'h00, 8'h05, 16'h0);
        issue("R1", 3'd0, 16'h1234, 8'h00, 8'h00, 8'h00, 8'h80, 16'h0);
        issue("R1", 3'd0, 16'h1234, 8'h00, 8'h00, 8'h00, 8'h7F, 16'h0);
        issue("R1", 3'd0, 16'hFFF0, 8'h00, 8'h00, 8'h00, 8'h20, 16'h0);
        issue("R1", 3'd0, 16'h0005, 8'h00, 8'h00, 8'h00, 8'hF0, 16'h0);
        idle(2);

        // R2, R3, R4: other arithmetic kinds, some back to back.
        issue("R2", 3'd1, 16'h0, 8'h00, 8'hCD, 8'hAB, 8'h00, 16'h0);
        issue("R3", 3'd2, 16'h0, 8'h70, 8'hFF, 8'h00, 8'h00, 16'h0);
        issue("R3", 3'd2, 16'h0, 8'h8C, 8'h00, 8'h00, 8'h00, 16'h0);
        issue("R3", 3'd2, 16'h0, 8'h5A, 8'h3C, 8'h00, 8'h00, 16'h0);
        issue("R4", 3'd4, 16'h0, 8'h00, 8'h00, 8'h00, 8'h00, 16'hBEEF);
        idle(3);

        // R5 / R6: table calls at both ends of the region, varied latency.
        for (int l = 0; l < 3; l++) begin
            lat = l;
            issue("R5", 3'd3, 16'h0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0);
            tag = "R6";
            idle(8);
            issue("R5", 3'd3, 16'h0, 8'hBE, 8'h00, 8'h00, 8'h00, 16'h0);
            tag = "R6";
            idle(8);
            issue("R5", 3'd3, 16'h0, 8'h15, 8'h00, 8'h00, 8'h00, 16'h0);
            tag = "R6";
            idle(8);
        end

        // R7: explicit vector refetch.
        lat = 2;
        issue("R7", 3'd5, 16'h0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0);
        idle(8);

        // R8: starts during a fetch are dropped; unused kinds do nothing.
        lat = 2;
        issue("R8", 3'd3, 16'h0, 8'h0A, 8'h00, 8'h00, 8'h00, 16'h0);
        issue("R8", 3'd0, 16'h4000, 8'h00, 8'h00, 8'h00, 8'h10, 16'h0);
        issue("R8", 3'd1, 16'h0, 8'h00, 8'h11, 8'h22, 8'h00, 16'h0);
        issue("R8", 3'd3, 16'h0, 8'h3E, 8'h00, 8'h00, 8'h00, 16'h0);
        issue("R8", 3'd4, 16'h0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h1357);
        idle(8);
        lat = 0;
        issue("R8", 3'd6, 16'h0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0);
        issue("R8", 3'd7, 16'h0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0);
        idle(3);

        // R9: output holds over a quiet stretch.
        tag = "R9";
        idle(5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule